// File: doc/BRIEF.md
# Receive Message Store with Arrival-Order Stamps

This block sits between a CEC receive engine and a host. The engine drops the bytes of an incoming message into a staging area, one byte at a time at an explicit byte index. It then gives an end-of-message strobe together with the message length. On that strobe the staged message is copied in one cycle into one of three receive slots. Each slot carries a 2-bit arrival stamp: 0 means the slot is free, and 1, 2 and 3 give the rank of the unread message it holds, with 1 the oldest.

The host reads any byte, the length and all three stamps through a combinational read port. It reads slots in rising stamp order. It releases slots by writing ones to a write-one-to-clear ready register. When a slot is released, the stamps of the slots still held close the gap, so the ranks always run densely from 1. A per-slot interrupt mask gates the ready bits onto a single interrupt line. A full flag tells the receive engine that nothing more can be taken. A message that ends while all slots are held is discarded and sets a sticky overflow flag.

Top module: `cec_rx_stamp_store`

## Requirements
- R1: After a synchronous reset, all stamps read 0, and the ready bits, overflow flag, full flag and interrupt are all 0.
- R2: A byte on `stg_data` with `stg_we` high is kept at staging index `stg_idx`. On `eom` (when not dropped), the staged bytes as they stood before that edge are copied into the lowest-numbered slot whose stamp is 0 after any same-cycle release. From the next cycle they read back on `rd_data` for `rd_slot`/`rd_idx`. A `rd_slot` value of 3 reads data 0 and length 0.
- R3: A stored message gets stamp N+1, where N is the number of slots still held after any same-cycle release.
- R4: The stored length is `eom_len` capped at 16. It is read back on `rd_len`.
- R5: Storing a message sets that slot's ready bit (bit i of `ready` is slot i). When `clr_we` is high, each slot whose `clr_bits` bit is 1 has its ready bit cleared and its stamp set to 0. A 1 for a slot that is already free changes nothing.
- R6: When slots are released, every remaining stamp drops by the number of released slots that had a smaller stamp. Held stamps therefore stay distinct and form the sequence 1..N.
- R7: `irq` is high exactly when some slot has both its ready bit and its `irq_mask` bit set. It follows `irq_mask` in the same cycle.
- R8: `full` is high when all three slots are held. An `eom` that finds all three slots held (after any same-cycle release) changes no slot, stamp or ready bit and sets `ovf`. `ovf` stays set until `ovf_clr` is pulsed. If a drop and `ovf_clr` happen in the same cycle, the set wins.
- R9: A release and an `eom` in the same cycle act as release first, then store. A full store that is also releasing a slot accepts the message.
- R10: The stamp of slot i appears on `stamps[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_we | input | 1 | Staging byte write enable |
| stg_idx | input | 4 | Staging byte index |
| stg_data | input | 8 | Staging byte value |
| eom | input | 1 | End-of-message strobe, commits staging |
| eom_len | input | 5 | Message length given with `eom` |
| full | output | 1 | All three slots hold unread messages |
| clr_we | input | 1 | Ready-register write strobe |
| clr_bits | input | 3 | Write-one-to-clear bits, one per slot |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| irq_mask | input | 3 | Per-slot interrupt enable |
| rd_slot | input | 2 | Host read slot select |
| rd_idx | input | 4 | Host read byte index |
| rd_data | output | 8 | Selected stored byte |
| rd_len | output | 5 | Stored length of selected slot |
| stamps | output | 6 | Arrival stamps of the three slots |
| ready | output | 3 | Ready bits per slot |
| irq | output | 1 | Masked interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Slot contents, stamps, ready bits, `full` and `ovf` are registered. Each is due one clock edge after the strobe that changes it. `rd_data`, `rd_len` and `irq` are combinational on the read select and mask, so they are due in the same cycle. The bench drives inputs just after the falling edge, waits a short delay and checks the combinational outputs against the bench model's current state. It then advances the model by one step, and checks the registered results at the next falling edge. Directed cases cover filling, overflow, releasing a middle rank, releasing and storing together, length capping and releasing a free slot. Random traffic from a fixed seed follows.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int NSLOT     = 3;
    localparam int STAMP_W   = 2;
    localparam int MAX_BYTES = 16;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int LEN_W     = $clog2(MAX_BYTES) + 1;
    localparam int SEL_W     = $clog2(NSLOT + 1);
    localparam int CNT_W     = $clog2(NSLOT + 1);

    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        byte_t [MAX_BYTES-1:0] bytes;
        len_t                  len;
    } msg_t;

    function automatic len_t cap_len(input len_t l);
        return (l > len_t'(MAX_BYTES)) ? len_t'(MAX_BYTES) : l;
    endfunction

    function automatic logic [CNT_W-1:0] count_held(input logic [NSLOT-1:0] v);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < NSLOT; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction
endpackage

// File: rtl/rxs_stage.sv
module rxs_stage
    import rxs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  idx,
    input  byte_t data,
    output byte_t [MAX_BYTES-1:0] staged
);
    byte_t [MAX_BYTES-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (we) begin
            stage_q[idx] <= data;
        end
    end

    assign staged = stage_q;

    p_stage_write_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> stage_q[$past(idx)] == $past(data));
endmodule

// File: rtl/rxs_slot_bank.sv
module rxs_slot_bank
    import rxs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSLOT-1:0]      store_oh,
    input  msg_t                  new_msg,
    input  logic [SEL_W-1:0]      rd_slot,
    input  idx_t                  rd_idx,
    output byte_t                 rd_data,
    output len_t                  rd_len
);
    msg_t slot_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (store_oh[s]) begin
                slot_q[s] <= new_msg;
            end
        end

        p_slot_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !store_oh[s] |=> $stable(slot_q[s]));
    end

    always_comb begin
        rd_data = '0;
        rd_len  = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_slot == SEL_W'(s)) begin
                rd_data = slot_q[s].bytes[rd_idx];
                rd_len  = slot_q[s].len;
            end
        end
    end

    p_one_store_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(store_oh));
endmodule

// File: rtl/rxs_stamp_ctrl.sv
module rxs_stamp_ctrl
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eom,
    input  logic             clr_we,
    input  logic [NSLOT-1:0] clr_bits,
    input  logic             ovf_clr,
    output stamp_t [NSLOT-1:0] stamp,
    output logic [NSLOT-1:0] ready,
    output logic [NSLOT-1:0] store_oh,
    output logic             full,
    output logic             ovf
);
    stamp_t [NSLOT-1:0] stamp_q, stamp_rel, stamp_d;
    logic   [NSLOT-1:0] ready_q, ready_d;
    logic   [NSLOT-1:0] freed, held_rel, held_q;
    logic   [CNT_W-1:0] n_rel;
    logic               drop, found, ovf_q;
    stamp_t             dec, max_q;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            freed[i] = clr_we && clr_bits[i] && (stamp_q[i] != '0);
        end
        // release first: close the rank gaps left by freed slots
        for (int i = 0; i < NSLOT; i++) begin
            dec = '0;
            for (int j = 0; j < NSLOT; j++) begin
                if (freed[j] && (stamp_q[j] < stamp_q[i])) dec = dec + 1'b1;
            end
            stamp_rel[i] = freed[i] ? '0 : (stamp_q[i] - dec);
            held_rel[i]  = (stamp_rel[i] != '0);
        end
        n_rel = count_held(held_rel);
        drop  = eom && (n_rel == CNT_W'(NSLOT));
        // then store into lowest free slot
        store_oh = '0;
        found    = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (eom && !drop && !found && !held_rel[i]) begin
                store_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
        stamp_d = stamp_rel;
        for (int i = 0; i < NSLOT; i++) begin
            if (store_oh[i]) stamp_d[i] = stamp_t'(n_rel + 1'b1);
        end
        ready_d = (ready_q & ~(clr_we ? clr_bits : '0)) | store_oh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= '0;
            ready_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            stamp_q <= stamp_d;
            ready_q <= ready_d;
            if (drop)         ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        max_q = '0;
        for (int i = 0; i < NSLOT; i++) begin
            held_q[i] = (stamp_q[i] != '0);
            if (stamp_q[i] > max_q) max_q = stamp_q[i];
        end
    end

    assign stamp = stamp_q;
    assign ready = ready_q;
    assign full  = &held_q;
    assign ovf   = ovf_q;

    p_ready_matches_stamp_r5: assert property (@(posedge clk) disable iff (rst)
        ready_q == held_q);

    p_stamps_dense_r6: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(max_q) == count_held(held_q)) &&
        ((stamp_q[0] != stamp_q[1]) || !held_q[0]) &&
        ((stamp_q[0] != stamp_q[2]) || !held_q[0]) &&
        ((stamp_q[1] != stamp_q[2]) || !held_q[1]));

    p_store_rank_r3: assert property (@(posedge clk) disable iff (rst)
        (eom && !full && !clr_we) |=>
            ($countones(held_q) == $past($countones(held_q)) + 1));

    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (eom && full && !clr_we) |=> ($stable(stamp_q) && ovf_q));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/cec_rx_stamp_store.sv
module cec_rx_stamp_store
    import rxs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stg_we,
    input  logic [3:0]  stg_idx,
    input  logic [7:0]  stg_data,
    input  logic        eom,
    input  logic [4:0]  eom_len,
    output logic        full,
    input  logic        clr_we,
    input  logic [2:0]  clr_bits,
    input  logic        ovf_clr,
    input  logic [2:0]  irq_mask,
    input  logic [1:0]  rd_slot,
    input  logic [3:0]  rd_idx,
    output logic [7:0]  rd_data,
    output logic [4:0]  rd_len,
    output logic [5:0]  stamps,
    output logic [2:0]  ready,
    output logic        irq,
    output logic        ovf
);
    byte_t [MAX_BYTES-1:0] staged;
    msg_t                  new_msg;
    stamp_t [NSLOT-1:0]    stamp_v;
    logic   [NSLOT-1:0]    store_oh;

    rxs_stage u_stage (
        .clk    (clk),
        .rst    (rst),
        .we     (stg_we),
        .idx    (stg_idx),
        .data   (stg_data),
        .staged (staged)
    );

    assign new_msg.bytes = staged;
    assign new_msg.len   = cap_len(eom_len);

    rxs_stamp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .eom      (eom),
        .clr_we   (clr_we),
        .clr_bits (clr_bits),
        .ovf_clr  (ovf_clr),
        .stamp    (stamp_v),
        .ready    (ready),
        .store_oh (store_oh),
        .full     (full),
        .ovf      (ovf)
    );

    rxs_slot_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .store_oh (store_oh),
        .new_msg  (new_msg),
        .rd_slot  (rd_slot),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_len   (rd_len)
    );

    assign stamps = stamp_v;
    assign irq    = |(ready & irq_mask);

    p_full_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
        full |-> (ready == 3'b111));

    p_len_capped_r4: assert property (@(posedge clk) disable iff (rst)
        rd_len <= 5'd16);
endmodule

// File: tb/tb_cec_rx_stamp_store.sv
module tb_cec_rx_stamp_store;
    logic       clk = 1'b0;
    logic       rst;
    logic       stg_we, eom, clr_we, ovf_clr;
    logic [3:0] stg_idx, rd_idx;
    logic [7:0] stg_data;
    logic [4:0] eom_len;
    logic [2:0] clr_bits, irq_mask;
    logic [1:0] rd_slot;
    logic       full, irq, ovf;
    logic [7:0] rd_data;
    logic [4:0] rd_len;
    logic [5:0] stamps;
    logic [2:0] ready;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int  m_st [3];
    bit  m_rdy [3];
    int  m_mem [3][16];
    int  m_len [3];
    int  m_stage [16];
    bit  m_ovf;

    always #10 clk = ~clk;

    cec_rx_stamp_store dut (
        .clk(clk), .rst(rst), .stg_we(stg_we), .stg_idx(stg_idx), .stg_data(stg_data),
        .eom(eom), .eom_len(eom_len), .full(full), .clr_we(clr_we), .clr_bits(clr_bits),
        .ovf_clr(ovf_clr), .irq_mask(irq_mask), .rd_slot(rd_slot), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_len(rd_len), .stamps(stamps), .ready(ready),
        .irq(irq), .ovf(ovf)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 3; i++) begin
            m_st[i] = 0; m_rdy[i] = 0; m_len[i] = 0;
            for (int b = 0; b < 16; b++) m_mem[i][b] = 0;
        end
        for (int b = 0; b < 16; b++) m_stage[b] = 0;
        m_ovf = 0;
    endfunction

    // one clock step of the requirement model: release, then store
    function automatic void model_step();
        bit fr [3];
        int ns [3];
        int held = 0;
        int tgt = -1;
        for (int i = 0; i < 3; i++) fr[i] = clr_we && clr_bits[i] && (m_st[i] != 0);
        for (int i = 0; i < 3; i++) begin
            int d = 0;
            for (int j = 0; j < 3; j++) if (fr[j] && m_st[j] < m_st[i]) d++;
            ns[i] = fr[i] ? 0 : (m_st[i] == 0 ? 0 : m_st[i] - d);
            if (ns[i] != 0) held++;
            if (clr_we && clr_bits[i]) m_rdy[i] = 0;
        end
        if (eom) begin
            if (held == 3) m_ovf = 1;
            else begin
                for (int i = 2; i >= 0; i--) if (ns[i] == 0) tgt = i;
                ns[tgt] = held + 1;
                m_rdy[tgt] = 1;
                m_len[tgt] = (eom_len > 16) ? 16 : int'(eom_len);
                for (int b = 0; b < 16; b++) m_mem[tgt][b] = m_stage[b];
            end
        end
        if (ovf_clr && !(eom && held == 3)) m_ovf = 0;
        if (stg_we) m_stage[stg_idx] = stg_data;
        for (int i = 0; i < 3; i++) m_st[i] = ns[i];
    endfunction

    function automatic int exp_irq();
        for (int i = 0; i < 3; i++) if (m_rdy[i] && irq_mask[i]) return 1;
        return 0;
    endfunction

    task automatic check_all(input string tag);
        int ed, el;
        ed = (rd_slot == 3) ? 0 : m_mem[rd_slot][rd_idx];
        el = (rd_slot == 3) ? 0 : m_len[rd_slot];
        chk("R2", {tag, " rd_data"}, rd_data, ed);
        chk("R4", {tag, " rd_len"}, rd_len, el);
        chk("R7", {tag, " irq"}, irq, exp_irq());
        for (int i = 0; i < 3; i++) begin
            chk("R10", {tag, " stamp"}, stamps[2*i +: 2], m_st[i]);
            chk("R5", {tag, " ready"}, ready[i], m_rdy[i]);
        end
        chk("R8", {tag, " full"}, full, (m_st[0] != 0 && m_st[1] != 0 && m_st[2] != 0));
        chk("R8", {tag, " ovf"}, ovf, m_ovf);
    endtask

    task automatic idle();
        stg_we = 0; eom = 0; clr_we = 0; ovf_clr = 0; clr_bits = 0;
    endtask

    // apply current inputs for one edge, then check registered results
    task automatic cycle(input string tag);
        #1 check_all({tag, " pre"});
        model_step();
        @(negedge clk);
        idle();
        #1 check_all({tag, " post"});
    endtask

    task automatic stage_msg(input int base, input int n);
        for (int b = 0; b < n; b++) begin
            stg_we = 1; stg_idx = 4'(b); stg_data = 8'(base + b);
            cycle("stage");
        end
    endtask

    task automatic commit(input int len, input string tag);
        eom = 1; eom_len = 5'(len);
        cycle(tag);
    endtask

    task automatic release_bits(input logic [2:0] m, input string tag);
        clr_we = 1; clr_bits = m;
        cycle(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_cec1));
        idle();
        stg_idx = 0; stg_data = 0; eom_len = 0; irq_mask = 3'b111; rd_slot = 0; rd_idx = 0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1 check_all("R1 reset");

        // R2 R3: fill three slots, lowest free first, ranks 1..3
        stage_msg(8'h10, 4); commit(4, "R2 first");
        stage_msg(8'h20, 3); commit(3, "R3 second");
        commit(20, "R4 cap third");
        chk("R8", "full after three", full, 1);
        // R8: drop while full
        commit(2, "R8 drop");
        chk("R8", "ovf after drop", ovf, 1);
        ovf_clr = 1; cycle("R8 ovf clear");
        // R6: release rank-2 slot (slot 1) -> slot 2 goes from 3 to 2
        release_bits(3'b010, "R6 release middle");
        chk("R6", "slot2 stamp", stamps[5:4], 2);
        // R5: releasing a free slot changes nothing
        release_bits(3'b010, "R5 free slot");
        // R9: fill again, then release and store together while full
        commit(5, "R3 refill");
        clr_we = 1; clr_bits = 3'b001; eom = 1; eom_len = 5'd7;
        cycle("R9 release+store");
        chk("R9", "slot0 stamp", stamps[1:0], 3);
        // R7: mask gating
        irq_mask = 3'b000; #1 chk("R7", "irq masked", irq, 0);
        irq_mask = 3'b100; #1 chk("R7", "irq one bit", irq, exp_irq());
        rd_slot = 3; #1 chk("R2", "slot 3 reads zero", rd_data, 0);
        release_bits(3'b111, "R5 release all");

        for (int k = 0; k < 4000; k++) begin
            stg_we   = ($urandom % 2) == 0;
            stg_idx  = 4'($urandom);
            stg_data = 8'($urandom);
            eom      = ($urandom % 4) == 0;
            eom_len  = 5'($urandom);
            clr_we   = ($urandom % 5) == 0;
            clr_bits = 3'($urandom);
            ovf_clr  = ($urandom % 16) == 0;
            irq_mask = 3'($urandom);
            rd_slot  = 2'($urandom);
            rd_idx   = 4'($urandom);
            cycle("rand");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule